// File: doc/BRIEF.md
# Segmented Sparse-Carry Binary Adder

A purely combinational adder for two wide unsigned operands plus a carry-in. It produces the sum and a carry-out. Timing and routing are kept under control by splitting the work in two. A parallel prefix tree delivers carries only at segment boundaries, spaced `SPARSE` bits apart. Each segment of `SPARSE` bits then finishes its own sum bits, taking its boundary carry as a late carry-in.

Inside a segment, the late carry-in drives only the carries into the even local positions. Each odd position takes its carry from the even carry just below it, through one more generate/propagate node. This roughly halves the load on the boundary carry.

The pair-level generate/propagate terms are formed once. The segment-local prefix built from them serves two purposes. Its top entry gives each segment's group term for the boundary tree. Its lower entries feed the segment's even carries directly.

Top module: `sparse_adder`

## Requirements
- R1: For every input, `{cout, sum}` equals the arithmetic value `a + b + cin` taken at `WIDTH+1` bits.
- R2: The result of R1 holds for each supported segment width: `SPARSE` of 8, 16 and 32 with `WIDTH` of 64.
- R3: A carry created in bit 0 travels through every segment. `a` all ones, `b` = 1, `cin` = 0 gives `sum` = 0 and `cout` = 1.
- R4: The external carry-in is the late carry-in of the lowest segment. With `a` = 0 and `b` = 0, `sum` equals `cin` and `cout` is 0. With `a` all ones, `b` = 0 and `cin` = 1, `sum` is 0 and `cout` is 1.
- R5: The carry-out is the group carry of the whole word, including `cin`. When every bit of `a ^ b` is 1, `cout` equals `cin`.
- R6: Each segment's own carry out of its top bit equals the tree's carry into the next boundary. A carry that starts below any bit position ends at the correct bit for every position.
- R7: Odd local positions take their carry from the even carry below them. Alternating bit patterns (0x55.. with 0xAA.., with either `cin`) give the correct sum.
- R8: With `WIDTH` = 128, both `SPARSE` = 16 and `SPARSE` = 32 give the correct result of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
Two functions decide the same output bits at once. One is the boundary tree, which carries a value across many segments. The other is the in-segment even/odd carry logic, which consumes that value as a late carry-in. The bench provokes both together by sweeping a run of ones of every length on one operand, with a single 1 at bit 0 or at the run's end. This makes the carry leave a segment through the tree and re-enter the next one through the late carry-in path, at every boundary and every interior position. Each result is judged against plain arithmetic for all three segment widths in the same cycle. An in-design check compares each segment's own top carry against the tree's next boundary carry.

// File: rtl/sparse_adder.sv
module sparse_adder #(
  parameter int WIDTH  = 64,
  parameter int SPARSE = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NSEG  = WIDTH / SPARSE;
  localparam int HALF  = SPARSE / 2;
  localparam int NPAIR = WIDTH / 2;

  logic [WIDTH-1:0] g, p, c;
  logic [NPAIR-1:0] pg, pp, lg, lp;
  logic [NSEG-1:0]  segg, segp;
  logic [NSEG:0]    bc;

  assign g = a & b;
  assign p = a ^ b;

  genvar gi;
  generate
    for (gi = 0; gi < NPAIR; gi++) begin : g_pair
      assign pg[gi] = g[2*gi+1] | (p[2*gi+1] & g[2*gi]);
      assign pp[gi] = p[2*gi+1] & p[2*gi];
    end
    for (gi = 0; gi < NSEG; gi++) begin : g_seg
      assign segg[gi] = lg[gi*HALF + HALF - 1];
      assign segp[gi] = lp[gi*HALF + HALF - 1];
    end
  endgenerate

  always_comb begin
    logic [NPAIR-1:0] ng, nq;
    lg = pg;
    lp = pp;
    for (int d = 1; d < HALF; d = d * 2) begin
      ng = lg;
      nq = lp;
      for (int j = 0; j < NPAIR; j++) begin
        if ((j % HALF) >= d) begin
          ng[j] = lg[j] | (lp[j] & lg[j-d]);
          nq[j] = lp[j] & lp[j-d];
        end
      end
      lg = ng;
      lp = nq;
    end
  end

  always_comb begin
    logic [NSEG:0] xg, xp, ng, nq;
    xg = {segg, cin};
    xp = {segp, 1'b0};
    for (int d = 1; d <= NSEG; d = d * 2) begin
      ng = xg;
      nq = xp;
      for (int j = 0; j <= NSEG; j++) begin
        if (j >= d) begin
          ng[j] = xg[j] | (xp[j] & xg[j-d]);
          nq[j] = xp[j] & xp[j-d];
        end
      end
      xg = ng;
      xp = nq;
    end
    bc = xg;
  end

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      if ((i % SPARSE) == 0)
        c[i] = bc[i / SPARSE];
      else if ((i % 2) == 0)
        c[i] = lg[i/2 - 1] | (lp[i/2 - 1] & bc[i / SPARSE]);
      else
        c[i] = g[i-1] | (p[i-1] & c[i-1]);
    end
  end

  assign sum  = p ^ c;
  assign cout = bc[NSEG];

  always_comb begin
    for (int s = 0; s < NSEG; s++) begin
      // R6
      seg_carry_chk: assert ((g[s*SPARSE+SPARSE-1] | (p[s*SPARSE+SPARSE-1] & c[s*SPARSE+SPARSE-1])) == bc[s+1])
        else $error("segment %0d top carry disagrees with boundary tree", s);
    end
    // R1
    arith_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("sum mismatch");
    // R4
    zero_operand_chk: assert (!((a == '0) && (b == '0)) || ((sum == {{(WIDTH-1){1'b0}}, cin}) && !cout))
      else $error("zero operands did not pass cin");
    // R5
    full_prop_chk: assert (!(&p) || (cout == cin))
      else $error("all-propagate cout differs from cin");
  end
endmodule

// File: tb/sparse_adder_bench.sv
module sparse_adder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [63:0]  a, b;
  logic         cin;
  logic [127:0] wa, wb;
  logic [63:0]  s8, s16, s32;
  logic         c8, c16, c32;
  logic [127:0] ws16, ws32;
  logic         wc16, wc32;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  sparse_adder #(.WIDTH(64), .SPARSE(8))  u_sparse_adder     (.a(a), .b(b), .cin(cin), .sum(s8),  .cout(c8));
  sparse_adder #(.WIDTH(64), .SPARSE(16)) u_sparse_adder_k16 (.a(a), .b(b), .cin(cin), .sum(s16), .cout(c16));
  sparse_adder #(.WIDTH(64), .SPARSE(32)) u_sparse_adder_k32 (.a(a), .b(b), .cin(cin), .sum(s32), .cout(c32));
  sparse_adder #(.WIDTH(128), .SPARSE(16)) u_sparse_adder_w16 (.a(wa), .b(wb), .cin(cin), .sum(ws16), .cout(wc16));
  sparse_adder #(.WIDTH(128), .SPARSE(32)) u_sparse_adder_w32 (.a(wa), .b(wb), .cin(cin), .sum(ws32), .cout(wc32));

  task automatic cmp64(string req, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%h b=%h cin=%0d act=%h exp=%h", req, a, b, cin, act, exp);
    end
  endtask

  task automatic cmp128(string req, logic [128:0] act, logic [128:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic [63:0] x, logic [63:0] y, logic ci);
    logic [64:0] e;
    @(posedge clk);
    a = x; b = y; cin = ci;
    @(negedge clk);
    e = {1'b0, x} + {1'b0, y} + {64'd0, ci};
    cmp64({req, " k8"},  {c8,  s8},  e);
    cmp64({req, " k16"}, {c16, s16}, e);
    cmp64({req, " k32"}, {c32, s32}, e);
  endtask

  task automatic apply_wide(string req, logic [127:0] x, logic [127:0] y, logic ci);
    logic [128:0] e;
    @(posedge clk);
    wa = x; wb = y; cin = ci;
    @(negedge clk);
    e = {1'b0, x} + {1'b0, y} + {128'd0, ci};
    cmp128({req, " w128 k16"}, {wc16, ws16}, e);
    cmp128({req, " w128 k32"}, {wc32, ws32}, e);
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; wa = '0; wb = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp64("reset R4 k8", {c8, s8}, 65'd0);
    apply("R3 ones plus one", '1, 64'd1, 1'b0);
    apply("R4 cin into zeros", 64'd0, 64'd0, 1'b1);
    apply("R4 cin into ones", '1, 64'd0, 1'b1);
    apply("R5 full propagate cin0", {32{2'b10}}, {32{2'b01}}, 1'b0);
    apply("R5 full propagate cin1", {32{2'b10}}, {32{2'b01}}, 1'b1);
    apply("R7 alternating", {16{4'h5}}, {16{4'h5}}, 1'b1);
    apply("R7 alternating mixed", {16{4'hA}}, {16{4'h6}}, 1'b0);
    apply("R7 alternating ones", {16{4'hA}}, {16{4'hA}}, 1'b1);
    for (int pos = 1; pos <= 64; pos++) begin
      logic [63:0] m;
      m = (pos == 64) ? '1 : ((64'd1 << pos) - 64'd1);
      apply("R6 run from bit0", m, 64'd1, 1'b0);
      apply("R6 run with cin", m, 64'd0, 1'b1);
      apply("R6 run to top", ~m, (pos == 64) ? 64'd0 : (64'd1 << pos), 1'b0);
    end
    for (int n = 0; n < 3000; n++)
      apply("R1 R2 random", {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
    apply_wide("R8 ones plus one", '1, 128'd1, 1'b0);
    apply_wide("R8 cin ones", '1, 128'd0, 1'b1);
    for (int n = 0; n < 500; n++)
      apply_wide("R8 random", {$urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom}, 1'($urandom));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired act=running exp=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule